// File: doc/BRIEF.md
# Linked-List Descriptor Chain Sequencer

This block steps one DMA channel through a multi-block transfer whose blocks are described by a chain of descriptors in memory. Software writes a starting pointer and pulses a start input. The block then enables the channel and reads the first descriptor through a single-word memory port. A descriptor holds a source address, a destination address, a next pointer and a 64-bit control word. The block presents these to a data mover and waits for the mover to report completion.

When a block finishes, the sequencer can read one status word for each side of the transfer. It can then write the updated upper control word and the status words back into the descriptor the block came from. After that it pulses a block interrupt. It does not wait for that interrupt to be serviced: it moves straight on to the next descriptor. A descriptor whose next pointer has a zero address field ends the chain. Each pointer carries a memory-layer select in its two low bits, and every access made on behalf of that descriptor goes out on that layer.

Top module: `desc_chain_dma`

## Requirements
- R1: After reset `ch_en`, `mem_req`, `mv_start`, `irq_block` and `irq_xfer` are low. A `ch_start` pulse while idle sets `ch_en` in the next cycle.
- R2: Each descriptor is read as five single-word reads, in this order: +0 source address, +4 destination address, +8 next pointer, +12 control low word, +16 control high word. The reads are relative to the pointer with bits [1:0] cleared and go out on layer = pointer bits [1:0].
- R3: After the fifth read, `mv_start` pulses for one cycle with `mv_src`, `mv_dst` and `mv_ctl` taken from the descriptor. The sequencer then waits for `mv_done`.
- R4: After `mv_done`, if `src_stat_en` is set the sequencer reads one word from `src_stat_addr`. After that, if `dst_stat_en` is set, it reads one word from `dst_stat_addr`. Both reads use the completed descriptor's layer. A disabled side makes no access.
- R5: With `ctl_wb_en` set, one write goes to completed-descriptor +16. It carries the fetched control high word with bits [11:0] replaced by `mv_count` and bit 12 (DONE) set; bits [31:13] are kept. With `ctl_wb_en` clear, no write is made.
- R6: The latched source status is written to completed-descriptor +20, followed by the destination status to +24. Each write happens only when `ctl_wb_en` and that side's enable are both set. The target is the descriptor the block was fetched from, even though the pointer register already holds the next pointer.
- R7: `irq_block` is a one-cycle pulse. It comes only after every status read and write-back for the block has completed, and no memory request is active in that cycle.
- R8: When the block was not the last one, the fetch of the next descriptor requests memory in the cycle after `irq_block`. No acknowledge is needed.
- R9: When the fetched next pointer has address bits [31:2] equal to zero, `irq_xfer` pulses together with `irq_block`. In the next cycle `ch_en` is low, and no further memory access follows, whatever layer bits that pointer holds.
- R10: A memory request keeps its address, direction, layer and write data stable until `mem_rdy` is high. The access completes in the cycle in which `mem_rdy` is high.
- R11: `ch_start` has no effect while the channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_start | input | 1 | Start pulse, accepted only when idle |
| start_ptr | input | 32 | First descriptor pointer (address with layer in [1:0]) |
| ctl_wb_en | input | 1 | Enables write-back into completed descriptors |
| src_stat_en | input | 1 | Enables source status read and write-back |
| dst_stat_en | input | 1 | Enables destination status read and write-back |
| src_stat_addr | input | 32 | Address of the source status word |
| dst_stat_addr | input | 32 | Address of the destination status word |
| ch_en | output | 1 | Channel active |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address of the access |
| mem_layer | output | 2 | Layer select of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Completes the current access |
| mv_start | output | 1 | Block start pulse to the mover |
| mv_src | output | 32 | Block source address |
| mv_dst | output | 32 | Block destination address |
| mv_ctl | output | 64 | Block control word |
| mv_done | input | 1 | Mover finished the block |
| mv_count | input | 12 | Items moved, valid with mv_done |
| irq_block | output | 1 | Block complete pulse |
| irq_xfer | output | 1 | Chain complete pulse |

## Verification
The hardest case to reach is a write-back that arrives after the pointer register has already moved on to the next descriptor. A wrong base address only shows up when neighbouring descriptors sit at different addresses and on different layers. The bench therefore builds chains whose descriptors each use a distinct address and layer, and inserts varying wait states on the memory port. The mover stub places fresh status words in memory just before it signals done, so reads, write-back data and targets can all be predicted. Further runs cover the enable combinations, a final pointer that has layer bits but a zero address, and a start pulse issued in the middle of a chain.

// File: rtl/dce_pkg.sv
// Shared definitions for the descriptor chain sequencer.
// Assumes 32-bit words, byte addresses and a fixed seven-word descriptor layout.
package dce_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RUN,
        ST_STAT,
        ST_WBCTL,
        ST_WBSTAT,
        ST_IRQ
    } dce_state_e;

    // Words loaded by a descriptor fetch, in fetch order
    localparam int unsigned DESC_WORDS = 5;
    localparam int unsigned IDX_SAR    = 0;
    localparam int unsigned IDX_DAR    = 1;
    localparam int unsigned IDX_LLP    = 2;
    localparam int unsigned IDX_CTLLO  = 3;
    localparam int unsigned IDX_CTLHI  = 4;

    // Byte offsets of write-back slots inside a descriptor
    localparam int unsigned OFF_CTLHI  = 16;
    localparam int unsigned OFF_SSTAT  = 20;
    localparam int unsigned OFF_DSTAT  = 24;

endpackage

// File: rtl/dce_desc_regs.sv
// Channel register file: holds the fetched descriptor words, the two latched
// status words and the completed block size. It also forms the updated control
// high word that is written back.
// Assumes that only one load strobe is active in any cycle.
module dce_desc_regs
    import dce_pkg::*;
#(
    parameter int unsigned DW   = 32,
    parameter int unsigned TS_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_set,
    input  logic [DW-1:0] ptr_val,
    input  logic          ld_en,
    input  logic [2:0]    ld_idx,
    input  logic [DW-1:0] ld_data,
    input  logic          st_src_ld,
    input  logic          st_dst_ld,
    input  logic          ts_ld,
    input  logic [TS_W-1:0] ts_val,
    output logic [DW-1:0] sar,
    output logic [DW-1:0] dar,
    output logic [DW-1:0] llp,
    output logic [DW-1:0] ctl_lo,
    output logic [DW-1:0] ctl_hi,
    output logic [DW-1:0] src_stat,
    output logic [DW-1:0] dst_stat,
    output logic [DW-1:0] ctl_hi_wb
);

    localparam int unsigned DONE_POS = TS_W;

    logic [DW-1:0]   word_q [DESC_WORDS];
    logic [DW-1:0]   stat_q [2];
    logic [1:0]      stat_ld;
    logic [TS_W-1:0] ts_q;

    assign stat_ld = {st_dst_ld, st_src_ld};

    // One register per descriptor word; the pointer word can also be preset at start
    for (genvar g = 0; g < int'(DESC_WORDS); g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (ptr_set && (g == int'(IDX_LLP))) begin
                word_q[g] <= ptr_val;
            end else if (ld_en && (ld_idx == 3'(g))) begin
                word_q[g] <= ld_data;
            end
        end
    end

    // Source (0) and destination (1) status latches, loaded from memory reads
    for (genvar s = 0; s < 2; s++) begin : g_stat
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q[s] <= '0;
            end else if (stat_ld[s]) begin
                stat_q[s] <= ld_data;
            end
        end
    end

    // Transferred count reported by the mover at the end of the block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else if (ts_ld) begin
            ts_q <= ts_val;
        end
    end

    assign sar       = word_q[IDX_SAR];
    assign dar       = word_q[IDX_DAR];
    assign llp       = word_q[IDX_LLP];
    assign ctl_lo    = word_q[IDX_CTLLO];
    assign ctl_hi    = word_q[IDX_CTLHI];
    assign src_stat  = stat_q[0];
    assign dst_stat  = stat_q[1];
    assign ctl_hi_wb = {ctl_hi[DW-1:DONE_POS+1], 1'b1, ts_q};

endmodule

// File: rtl/dce_seq.sv
// Sequencer for one channel: walks the descriptor chain and issues every
// memory access (fetch, status read, write-back). It starts the mover and
// raises the block and chain interrupts.
// Assumes the enables and status addresses stay constant while the channel runs.
module dce_seq
    import dce_pkg::*;
#(
    parameter int unsigned DW      = 32,
    parameter int unsigned LAYER_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ch_start,
    input  logic [DW-1:0]      start_ptr,
    input  logic               ctl_wb_en,
    input  logic               src_stat_en,
    input  logic               dst_stat_en,
    input  logic [DW-1:0]      src_stat_addr,
    input  logic [DW-1:0]      dst_stat_addr,
    input  logic               mv_done,
    input  logic               mem_rdy,
    input  logic [DW-1:0]      llp,
    input  logic [DW-1:0]      ctl_hi_wb,
    input  logic [DW-1:0]      src_stat,
    input  logic [DW-1:0]      dst_stat,
    output logic               ch_en,
    output logic               mv_start,
    output logic               mem_req,
    output logic               mem_we,
    output logic [DW-1:0]      mem_addr,
    output logic [LAYER_W-1:0] mem_layer,
    output logic [DW-1:0]      mem_wdata,
    output logic               ptr_set,
    output logic               ld_en,
    output logic [2:0]         ld_idx,
    output logic               st_src_ld,
    output logic               st_dst_ld,
    output logic               ts_ld,
    output logic               irq_block,
    output logic               irq_xfer
);

    localparam logic [2:0] LAST_WORD = 3'(DESC_WORDS - 1);

    dce_state_e    state_q;
    logic [2:0]    step_q;
    logic [DW-1:0] cur_q;
    logic          en_q;
    logic          mvs_q;
    logic [DW-1:0] base;
    logic          side_dst;
    logic          last_blk;
    logic          step_go;

    assign base     = {cur_q[DW-1:LAYER_W], {LAYER_W{1'b0}}};
    assign side_dst = step_q[0];
    assign last_blk = (llp[DW-1:LAYER_W] == '0);
    assign step_go  = !mem_req || mem_rdy;

    // Decode the memory request of the current state and step
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = base;
        mem_wdata = '0;
        case (state_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = base + DW'({step_q, 2'b00});
            end
            ST_STAT: begin
                mem_req  = side_dst ? dst_stat_en : src_stat_en;
                mem_addr = side_dst ? dst_stat_addr : src_stat_addr;
            end
            ST_WBCTL: begin
                mem_req   = ctl_wb_en;
                mem_we    = 1'b1;
                mem_addr  = base + DW'(OFF_CTLHI);
                mem_wdata = ctl_hi_wb;
            end
            ST_WBSTAT: begin
                mem_req   = ctl_wb_en && (side_dst ? dst_stat_en : src_stat_en);
                mem_we    = 1'b1;
                mem_addr  = base + (side_dst ? DW'(OFF_DSTAT) : DW'(OFF_SSTAT));
                mem_wdata = side_dst ? dst_stat : src_stat;
            end
            default: ;
        endcase
    end

    assign mem_layer = cur_q[LAYER_W-1:0];
    assign ch_en     = en_q;
    assign mv_start  = mvs_q;
    assign ptr_set   = (state_q == ST_IDLE) && ch_start;
    assign ld_en     = (state_q == ST_FETCH) && mem_rdy;
    assign ld_idx    = step_q;
    assign st_src_ld = (state_q == ST_STAT) && !side_dst && mem_req && mem_rdy;
    assign st_dst_ld = (state_q == ST_STAT) && side_dst && mem_req && mem_rdy;
    assign ts_ld     = (state_q == ST_RUN) && mv_done;
    assign irq_block = (state_q == ST_IRQ);
    assign irq_xfer  = irq_block && last_blk;

    // State, step counter, descriptor base and channel enable update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            cur_q   <= '0;
            en_q    <= 1'b0;
            mvs_q   <= 1'b0;
        end else begin
            mvs_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (ch_start) begin
                        en_q    <= 1'b1;
                        cur_q   <= start_ptr;
                        step_q  <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_rdy) begin
                        if (step_q == LAST_WORD) begin
                            step_q  <= '0;
                            mvs_q   <= 1'b1;
                            state_q <= ST_RUN;
                        end else begin
                            step_q <= step_q + 3'd1;
                        end
                    end
                end
                ST_RUN: begin
                    if (mv_done) begin
                        step_q  <= '0;
                        state_q <= ST_STAT;
                    end
                end
                ST_STAT: begin
                    if (step_go) begin
                        if (side_dst) begin
                            step_q  <= '0;
                            state_q <= ST_WBCTL;
                        end else begin
                            step_q <= 3'd1;
                        end
                    end
                end
                ST_WBCTL: begin
                    if (step_go) begin
                        step_q  <= '0;
                        state_q <= ST_WBSTAT;
                    end
                end
                ST_WBSTAT: begin
                    if (step_go) begin
                        if (side_dst) begin
                            step_q  <= '0;
                            state_q <= ST_IRQ;
                        end else begin
                            step_q <= 3'd1;
                        end
                    end
                end
                ST_IRQ: begin
                    step_q <= '0;
                    if (last_blk) begin
                        en_q    <= 1'b0;
                        state_q <= ST_IDLE;
                    end else begin
                        cur_q   <= llp;
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_layer) && $stable(mem_wdata));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_block |-> !mem_req && !mv_start);

    // R9
    xfer_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_xfer |=> !ch_en && !mem_req);

    // R6
    wb_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> (mem_addr == base + DW'(OFF_CTLHI)) ||
                              (mem_addr == base + DW'(OFF_SSTAT)) ||
                              (mem_addr == base + DW'(OFF_DSTAT)));

    // R3
    mv_start_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |-> ch_en && !mem_req);

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_en && ch_start && !irq_block |=> ch_en && $stable(cur_q));

endmodule

// File: rtl/desc_chain_dma.sv
// Top level of the descriptor chain sequencer: joins the sequencer to the
// channel register file and exposes the memory port and the mover port.
// Assumes a 32-bit word memory and pointers whose two low bits select the layer.
module desc_chain_dma #(
    parameter int unsigned DW      = 32,
    parameter int unsigned TS_W    = 12,
    parameter int unsigned LAYER_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ch_start,
    input  logic [DW-1:0]      start_ptr,
    input  logic               ctl_wb_en,
    input  logic               src_stat_en,
    input  logic               dst_stat_en,
    input  logic [DW-1:0]      src_stat_addr,
    input  logic [DW-1:0]      dst_stat_addr,
    output logic               ch_en,
    output logic               mem_req,
    output logic               mem_we,
    output logic [DW-1:0]      mem_addr,
    output logic [LAYER_W-1:0] mem_layer,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               mem_rdy,
    output logic               mv_start,
    output logic [DW-1:0]      mv_src,
    output logic [DW-1:0]      mv_dst,
    output logic [2*DW-1:0]    mv_ctl,
    input  logic               mv_done,
    input  logic [TS_W-1:0]    mv_count,
    output logic               irq_block,
    output logic               irq_xfer
);

    logic          ptr_set;
    logic          ld_en;
    logic [2:0]    ld_idx;
    logic          st_src_ld;
    logic          st_dst_ld;
    logic          ts_ld;
    logic [DW-1:0] llp;
    logic [DW-1:0] ctl_lo;
    logic [DW-1:0] ctl_hi;
    logic [DW-1:0] src_stat;
    logic [DW-1:0] dst_stat;
    logic [DW-1:0] ctl_hi_wb;

    dce_seq #(
        .DW      (DW),
        .LAYER_W (LAYER_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .ch_start      (ch_start),
        .start_ptr     (start_ptr),
        .ctl_wb_en     (ctl_wb_en),
        .src_stat_en   (src_stat_en),
        .dst_stat_en   (dst_stat_en),
        .src_stat_addr (src_stat_addr),
        .dst_stat_addr (dst_stat_addr),
        .mv_done       (mv_done),
        .mem_rdy       (mem_rdy),
        .llp           (llp),
        .ctl_hi_wb     (ctl_hi_wb),
        .src_stat      (src_stat),
        .dst_stat      (dst_stat),
        .ch_en         (ch_en),
        .mv_start      (mv_start),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_layer     (mem_layer),
        .mem_wdata     (mem_wdata),
        .ptr_set       (ptr_set),
        .ld_en         (ld_en),
        .ld_idx        (ld_idx),
        .st_src_ld     (st_src_ld),
        .st_dst_ld     (st_dst_ld),
        .ts_ld         (ts_ld),
        .irq_block     (irq_block),
        .irq_xfer      (irq_xfer)
    );

    dce_desc_regs #(
        .DW   (DW),
        .TS_W (TS_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_set   (ptr_set),
        .ptr_val   (start_ptr),
        .ld_en     (ld_en),
        .ld_idx    (ld_idx),
        .ld_data   (mem_rdata),
        .st_src_ld (st_src_ld),
        .st_dst_ld (st_dst_ld),
        .ts_ld     (ts_ld),
        .ts_val    (mv_count),
        .sar       (mv_src),
        .dar       (mv_dst),
        .llp       (llp),
        .ctl_lo    (ctl_lo),
        .ctl_hi    (ctl_hi),
        .src_stat  (src_stat),
        .dst_stat  (dst_stat),
        .ctl_hi_wb (ctl_hi_wb)
    );

    assign mv_ctl = {ctl_hi, ctl_lo};

endmodule

// File: tb/desc_chain_dma_test.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task predicts every memory access, mover start
// and interrupt from the chain in the memory model, and queues them. A monitor
// process pops each expected item as the design produces the matching event.
module desc_chain_dma_test;

    localparam logic [1:0] K_ACC = 2'd0, K_MVS = 2'd1, K_IRQB = 2'd2, K_IRQX = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic        we;
        logic [1:0]  layer;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  req;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_start = 1'b0;
    logic [31:0] start_ptr = '0;
    logic        ctl_wb_en = 1'b0, src_stat_en = 1'b0, dst_stat_en = 1'b0;
    logic [31:0] src_stat_addr = 32'h800, dst_stat_addr = 32'h804;
    logic        ch_en, mem_req, mem_we, mv_start, irq_block, irq_xfer;
    logic [31:0] mem_addr, mem_wdata, mv_src, mv_dst;
    logic [1:0]  mem_layer;
    logic [63:0] mv_ctl;
    logic [31:0] mem_rdata = '0;
    logic        mem_rdy = 1'b0;
    logic        mv_done = 1'b0;
    logic [11:0] mv_count = '0;

    always #2 clk = ~clk;

    desc_chain_dma uut (
        .clk(clk), .rst_n(rst_n), .ch_start(ch_start), .start_ptr(start_ptr),
        .ctl_wb_en(ctl_wb_en), .src_stat_en(src_stat_en), .dst_stat_en(dst_stat_en),
        .src_stat_addr(src_stat_addr), .dst_stat_addr(dst_stat_addr),
        .ch_en(ch_en), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_layer(mem_layer), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rdy(mem_rdy), .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst),
        .mv_ctl(mv_ctl), .mv_done(mv_done), .mv_count(mv_count),
        .irq_block(irq_block), .irq_xfer(irq_xfer)
    );

    logic [31:0] mem [0:1023];
    ev_t exp_q[$];
    int total = 0, bad = 0;
    int exp_blk = 0, mv_seq = 0, mv_cd = -1;
    int wcnt = 0, wmax = 0, acc_n = 0;
    bit xfer_seen = 0, prev_irqb = 0, prev_irqx = 0;
    logic        cap_we;
    logic [1:0]  cap_layer;
    logic [31:0] cap_addr, cap_data;

    function automatic int widx(input logic [31:0] a);
        return int'(a[11:2]);
    endfunction
    function automatic logic [11:0] cnt_of(input int n);
        return 12'(n * 37 + 5);
    endfunction
    function automatic logic [31:0] sstat_of(input int n);
        return 32'h5A00_0000 + 32'(n);
    endfunction
    function automatic logic [31:0] dstat_of(input int n);
        return 32'hD700_0000 + 32'(n);
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_ev(input logic [1:0] k, input logic w, input logic [1:0] l,
                           input logic [31:0] a, input logic [31:0] d, input int r);
        ev_t e;
        e.kind = k; e.we = w; e.layer = l; e.addr = a; e.data = d; e.req = 4'(r);
        exp_q.push_back(e);
    endtask

    // Monitor side: compare one observed event with the queue head
    task automatic observe(input logic [1:0] k, input logic w, input logic [1:0] l,
                           input logic [31:0] a, input logic [31:0] d);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R10 unexpected event", {k, w, l, a, d}, '0);
        end else begin
            e = exp_q.pop_front();
            check({e.kind, e.we, e.layer, e.addr, e.data} == {k, w, l, a, d},
                  $sformatf("R%0d", e.req), {k, w, l, a, d},
                  {e.kind, e.we, e.layer, e.addr, e.data});
        end
    endtask

    task automatic set_desc(input logic [31:0] a, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] nxt, input logic [31:0] lo, input logic [31:0] hi);
        mem[widx(a)]      = s;
        mem[widx(a) + 1]  = d;
        mem[widx(a) + 2]  = nxt;
        mem[widx(a) + 3]  = lo;
        mem[widx(a) + 4]  = hi;
        mem[widx(a) + 5]  = '0;
        mem[widx(a) + 6]  = '0;
    endtask

    // Driver side: predict every event of one block
    task automatic expect_block(input logic [31:0] p, input bit wb, input bit se, input bit de);
        logic [31:0] b = {p[31:2], 2'b00};
        logic [1:0]  ly = p[1:0];
        logic [31:0] hi = mem[widx(b) + 4];
        logic [31:0] nx = mem[widx(b) + 2];
        for (int w = 0; w < 5; w++)                    // R2 fetch order
            push_ev(K_ACC, 1'b0, ly, b + 32'(4 * w), mem[widx(b) + w], 2);
        push_ev(K_MVS, 1'b0, 2'b00, mem[widx(b) + 1], mem[widx(b)], 3);      // R3
        if (se) push_ev(K_ACC, 1'b0, ly, src_stat_addr, sstat_of(exp_blk), 4); // R4
        if (de) push_ev(K_ACC, 1'b0, ly, dst_stat_addr, dstat_of(exp_blk), 4);
        if (wb) push_ev(K_ACC, 1'b1, ly, b + 32'd16, {hi[31:13], 1'b1, cnt_of(exp_blk)}, 5); // R5
        if (wb && se) push_ev(K_ACC, 1'b1, ly, b + 32'd20, sstat_of(exp_blk), 6); // R6
        if (wb && de) push_ev(K_ACC, 1'b1, ly, b + 32'd24, dstat_of(exp_blk), 6);
        push_ev(K_IRQB, 1'b0, 2'b00, '0, '0, 7);                            // R7
        if (nx[31:2] == '0) push_ev(K_IRQX, 1'b0, 2'b00, '0, '0, 9);        // R9
        exp_blk++;
    endtask

    task automatic run_test(input logic [31:0] p0, input bit wb, input bit se, input bit de,
                            input int wm, input bit poke);
        logic [31:0] p = p0;
        int t = 0;
        ctl_wb_en = wb; src_stat_en = se; dst_stat_en = de; wmax = wm;
        do begin
            expect_block(p, wb, se, de);
            p = mem[widx({p[31:2], 2'b00}) + 2];
        end while (p[31:2] != '0);
        xfer_seen = 0;
        @(negedge clk); ch_start = 1'b1; start_ptr = p0;
        @(negedge clk); ch_start = 1'b0;
        check(ch_en === 1'b1, "R1 start", {127'b0, ch_en}, 128'd1);
        if (poke) begin
            repeat (6) @(negedge clk);
            ch_start = 1'b1; start_ptr = 32'h101;
            @(negedge clk); ch_start = 1'b0;
            check(ch_en === 1'b1, "R11", {127'b0, ch_en}, 128'd1);
        end
        while (!xfer_seen && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (!xfer_seen) check(1'b0, "R9 watchdog", 128'(t), 128'd0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9 leftover", 128'(exp_q.size()), 128'd0);
        exp_q.delete();
    endtask

    // Memory model, mover stub and event monitor, all stepped away from the clock edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rdy = 1'b0;
            mv_done = 1'b0;
        end else begin
            if (mem_rdy) begin                         // R10: access completed at last edge
                observe(K_ACC, cap_we, cap_layer, cap_addr, cap_data);
                if (cap_we) mem[widx(cap_addr)] = cap_data;
                mem_rdy = 1'b0;
            end
            if (prev_irqb && !prev_irqx)               // R8
                check(mem_req === 1'b1, "R8", {127'b0, mem_req}, 128'd1);
            if (prev_irqx)                             // R9
                check(!ch_en && !mem_req, "R9 end", {126'b0, ch_en, mem_req}, 128'd0);
            if (mv_start) begin
                observe(K_MVS, 1'b0, 2'b00, mv_dst, mv_src);
                mv_cd = 2 + (mv_seq % 3);
            end
            if (irq_block) observe(K_IRQB, 1'b0, 2'b00, '0, '0);
            if (irq_xfer) begin
                observe(K_IRQX, 1'b0, 2'b00, '0, '0);
                xfer_seen = 1;
            end
            prev_irqb = irq_block;
            prev_irqx = irq_xfer;
            mv_done = 1'b0;
            if (mv_cd == 0) begin
                mem[widx(src_stat_addr)] = sstat_of(mv_seq);
                mem[widx(dst_stat_addr)] = dstat_of(mv_seq);
                mv_count = cnt_of(mv_seq);
                mv_done  = 1'b1;
                mv_seq++;
                mv_cd = -1;
            end else if (mv_cd > 0) begin
                mv_cd--;
            end
            if (mem_req && !mem_rdy) begin
                if (wcnt >= acc_n % (wmax + 1)) begin
                    cap_we    = mem_we;
                    cap_layer = mem_layer;
                    cap_addr  = mem_addr;
                    if (!mem_we) mem_rdata = mem[widx(mem_addr)];
                    cap_data  = mem_we ? mem_wdata : mem_rdata;
                    mem_rdy   = 1'b1;
                    wcnt = 0;
                    acc_n++;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R10 global watchdog", '0, '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!ch_en && !mem_req && !mv_start && !irq_block && !irq_xfer, "R1 reset",
              {123'b0, ch_en, mem_req, mv_start, irq_block, irq_xfer}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Three blocks on layers 1,2,3; final pointer has layer bits but zero address
        set_desc(32'h100, 32'h1111_0000, 32'h2222_0000, 32'h0000_0142, 32'h0000_00A1, 32'h7E5A_4FFF);
        set_desc(32'h140, 32'h1111_0100, 32'h2222_0100, 32'h0000_0183, 32'h0000_00A2, 32'hFFFF_E000);
        set_desc(32'h180, 32'h1111_0200, 32'h2222_0200, 32'h0000_0002, 32'h0000_00A3, 32'h0000_1ABC);
        run_test(32'h0000_0101, 1'b1, 1'b1, 1'b1, 2, 1'b0);

        // No write-back, source status only, no memory wait states
        set_desc(32'h200, 32'h3333_0000, 32'h4444_0000, 32'h0000_0241, 32'h0000_00B1, 32'h1234_5678);
        set_desc(32'h240, 32'h3333_0100, 32'h4444_0100, 32'h0000_0000, 32'h0000_00B2, 32'h8765_4321);
        run_test(32'h0000_0200, 1'b0, 1'b1, 1'b0, 0, 1'b0);

        // Single block, destination status only, start pulse while busy (R11)
        set_desc(32'h300, 32'h5555_0000, 32'h6666_0000, 32'h0000_0000, 32'h0000_00C1, 32'hAAAA_AFFF);
        run_test(32'h0000_0302, 1'b1, 1'b0, 1'b1, 3, 1'b1);

        // Control write-back only, both status sides disabled
        set_desc(32'h380, 32'h7777_0000, 32'h8888_0000, 32'h0000_03C0, 32'h0000_00D1, 32'h0F0F_0000);
        set_desc(32'h3C0, 32'h7777_0100, 32'h8888_0100, 32'h0000_0001, 32'h0000_00D2, 32'hF0F0_1FFF);
        run_test(32'h0000_0381, 1'b1, 1'b0, 1'b0, 1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule